// File: doc/BRIEF.md
# SMBus Slave Message Decoder

This block is the receive side of a small SMBus target. It watches the clock and data lines and matches each transfer against a 7-bit address register that the host can program. It accepts three message shapes. A Byte Write delivers a command and a data byte, and both are stored for the host. A Byte Read returns one byte from a local register file, selected by a command byte that the master writes first; the master then issues a repeated START and a read address. A Host Notify, sent to the reserved host address, carries a device byte and a 16-bit word, and these are captured in their own registers.

A message that completes sets one of two sticky status bits. Notify messages set the notify status bit, and every other message sets the event status bit. Each status bit drives its own interrupt line. The block never sends or accepts a packet-error-check byte. A bus that stays fully idle in the middle of a transfer drops the decoder back to idle, and no register changes.

Top module: `smb_slave_decoder`

## Requirements
- R1: The own-address register resets to 7'h44 and changes only when the host writes it through the configuration port.
- R2: An address byte is {address[6:0], rw} with rw=0 for write. The block ACKs its own write address. It NACKs any other address except the notify host address and then ignores the bus until the next START.
- R3: Byte Write (own write address, command, data, STOP) updates rx_cmd and rx_data at the STOP and sets the event status.
- R4: Byte Read (own write address, command, repeated START, own read address) returns one byte, MSB first, equal to register-file entry [command] when command < RF_DEPTH and 8'hFF otherwise. The event status sets at the STOP.
- R5: Host Notify (write to 7'h08, i.e. byte 8'h10, then device byte, low byte, high byte) stores nt_addr and nt_data = {high, low} at the STOP. It sets the notify status and leaves the event status unchanged.
- R6: A byte that follows a complete Byte Write or Host Notify payload is NACKed, and the whole message is discarded without any register update.
- R7: If SCL and SDA both stay high for TO_CYC clock cycles in the middle of a transfer, the decoder returns to idle, and a later STOP commits nothing.
- R8: Each interrupt output equals its status bit. A one-cycle clear pulse clears the status bit, but a set in the same cycle wins.
- R9: A read address that arrives without a preceding command byte in the same transfer is NACKed.
- R10: The block changes its SDA pull-down only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| cfg_addr_we | input | 1 | Host write strobe for the own address |
| cfg_addr | input | 7 | New own address |
| rf_we | input | 1 | Host write strobe for the register file |
| rf_idx | input | RF_IW | Register-file entry to write |
| rf_wdata | input | 8 | Register-file write data |
| clr_notify | input | 1 | Clears the notify status |
| clr_event | input | 1 | Clears the event status |
| slv_addr | output | 7 | Current own address |
| rx_cmd | output | 8 | Last Byte Write command |
| rx_data | output | 8 | Last Byte Write data |
| nt_addr | output | 8 | Last Host Notify device byte |
| nt_data | output | 16 | Last Host Notify word |
| stat_notify | output | 1 | Sticky notify status |
| stat_event | output | 1 | Sticky status for other messages |
| irq_notify | output | 1 | Notify interrupt |
| irq_event | output | 1 | Event interrupt |

## Verification
A table of Byte Writes mixes the own address, neighbouring addresses and unrelated addresses. This separates address matching from data capture, because a NACKed entry must leave the last stored values in place. Byte Reads use an in-range command, an out-of-range command, and a read address with no command before it, which covers lookup, the 8'hFF fill value and the repeated-START condition. Host Notify is checked against the event status so that the two status paths cannot be confused. An over-long write and a stalled idle bus show that incomplete or excess messages never commit.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_DATA, PH_WDONE,
    PH_NADDR, PH_NLO, PH_NHI, PH_NDONE,
    PH_TX, PH_RDONE, PH_IGNORE
  } phase_t;

  localparam logic [6:0] HOST_NOTIFY_ADDR = 7'h08;
  localparam logic [6:0] ADDR_AT_RESET    = 7'h44;
  localparam logic [7:0] FILL_BYTE        = 8'hFF;

  // Wire form of an address: 7-bit address above the direction bit.
  function automatic logic [7:0] wire_addr(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a, input logic rw);
    return b == wire_addr(a, rw);
  endfunction

  function automatic logic [15:0] notify_word(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] raw;
  logic [1:0] now_v;
  logic [1:0] old_v;

  assign raw = {sda_raw, scl_raw};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[SYNC_STAGES-1:0], raw[i]};
    end
    assign now_v[i] = pipe[SYNC_STAGES-1];
    assign old_v[i] = pipe[SYNC_STAGES];
  end

  assign scl_s     = now_v[0];
  assign sda_s     = now_v[1];
  assign scl_rise  = now_v[0] & ~old_v[0];
  assign scl_fall  = ~now_v[0] & old_v[0];
  assign start_evt = now_v[0] & old_v[0] & old_v[1] & ~now_v[1];
  assign stop_evt  = now_v[0] & old_v[0] & ~old_v[1] & now_v[1];

endmodule

// File: rtl/smb_msg_fsm.sv
module smb_msg_fsm
  import smb_pkg::*;
#(
  parameter int TO_CYC = 5000,
  localparam int TO_W = $clog2(TO_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] own_addr,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic [7:0] cmd_q,
  output logic [7:0] data_q,
  output logic [7:0] naddr_q,
  output logic [7:0] nlo_q,
  output logic [7:0] nhi_q,
  output logic       wr_commit,
  output logic       nt_commit,
  output logic       rd_commit
);
  phase_t      phase, nxt_ph;
  logic [3:0]  bit_idx;
  logic [7:0]  sh;
  logic [7:0]  tx_sh;
  logic        tx_en;
  logic        cmd_ok;
  logic        oe_q;
  logic        nxt_ack;
  logic [TO_W-1:0] idle_cnt;
  logic        to_hit;
  logic        active;
  logic        byte_done;

  assign active    = (phase != PH_IDLE) && (phase != PH_IGNORE);
  assign to_hit    = (phase != PH_IDLE) && scl_s && sda_s && (idle_cnt == TO_W'(TO_CYC - 1));
  assign byte_done = active && !to_hit && !start_evt && !stop_evt &&
                     scl_fall && (bit_idx == 4'd8) && !tx_en;

  assign wr_commit = stop_evt && !to_hit && (phase == PH_WDONE);
  assign nt_commit = stop_evt && !to_hit && (phase == PH_NDONE);
  assign rd_commit = stop_evt && !to_hit && (phase == PH_RDONE);
  assign sda_oe    = oe_q;

  // Decision for a completed received byte.
  always_comb begin
    nxt_ph  = PH_IGNORE;
    nxt_ack = 1'b0;
    case (phase)
      PH_ADDR: begin
        if (addr_hit(sh, own_addr, 1'b0)) begin
          nxt_ph = PH_CMD;   nxt_ack = 1'b1;
        end else if (addr_hit(sh, own_addr, 1'b1) && cmd_ok) begin
          nxt_ph = PH_TX;    nxt_ack = 1'b1;
        end else if (addr_hit(sh, HOST_NOTIFY_ADDR, 1'b0)) begin
          nxt_ph = PH_NADDR; nxt_ack = 1'b1;
        end
      end
      PH_CMD:   begin nxt_ph = PH_DATA;  nxt_ack = 1'b1; end
      PH_DATA:  begin nxt_ph = PH_WDONE; nxt_ack = 1'b1; end
      PH_NADDR: begin nxt_ph = PH_NLO;   nxt_ack = 1'b1; end
      PH_NLO:   begin nxt_ph = PH_NHI;   nxt_ack = 1'b1; end
      PH_NHI:   begin nxt_ph = PH_NDONE; nxt_ack = 1'b1; end
      default:  begin nxt_ph = PH_IGNORE; nxt_ack = 1'b0; end
    endcase
  end

  // Bus-idle watchdog inside a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   idle_cnt <= '0;
    else if (phase == PH_IDLE || !(scl_s && sda_s)) idle_cnt <= '0;
    else if (!to_hit)                             idle_cnt <= idle_cnt + 1'b1;
    else                                          idle_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      sh      <= '0;
      tx_sh   <= '1;
      tx_en   <= 1'b0;
      cmd_ok  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (to_hit) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      tx_en   <= 1'b0;
      cmd_ok  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_ADDR;
      bit_idx <= '0;
      tx_en   <= 1'b0;
      cmd_ok  <= (phase == PH_DATA);
      oe_q    <= 1'b0;
    end else if (stop_evt) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      tx_en   <= 1'b0;
      cmd_ok  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_idx < 4'd8) begin
          if (!tx_en) sh <= {sh[6:0], sda_s};
          bit_idx <= bit_idx + 1'b1;
        end else if (bit_idx == 4'd8) begin
          bit_idx <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bit_idx == 4'd8) begin
          if (tx_en) begin
            oe_q <= 1'b0;
          end else begin
            oe_q  <= nxt_ack;
            phase <= nxt_ph;
          end
        end else if (bit_idx == 4'd9) begin
          bit_idx <= '0;
          if (phase == PH_TX && !tx_en) begin
            tx_en <= 1'b1;
            tx_sh <= rd_byte;
            oe_q  <= ~rd_byte[7];
          end else begin
            oe_q <= 1'b0;
            if (tx_en) begin
              tx_en <= 1'b0;
              phase <= PH_RDONE;
            end
          end
        end else if (tx_en && bit_idx != 4'd0) begin
          tx_sh <= {tx_sh[6:0], 1'b1};
          oe_q  <= ~tx_sh[6];
        end
      end
    end
  end

  // Captured payload bytes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; data_q <= '0; naddr_q <= '0; nlo_q <= '0; nhi_q <= '0;
    end else if (byte_done) begin
      case (phase)
        PH_CMD:   cmd_q   <= sh;
        PH_DATA:  data_q  <= sh;
        PH_NADDR: naddr_q <= sh;
        PH_NLO:   nlo_q   <= sh;
        PH_NHI:   nhi_q   <= sh;
        default: ;
      endcase
    end
  end

  // R10: pull-down changes only while SCL is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R7: stalled idle bus returns the decoder to idle
  p_timeout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (phase == PH_IDLE) && !oe_q);

  // R2: never drives the bus while ignoring it
  p_quiet_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !oe_q);

endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
#(
  parameter int RF_DEPTH = 8,
  localparam int RF_IW = (RF_DEPTH > 1) ? $clog2(RF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_addr_we,
  input  logic [6:0]       cfg_addr,
  input  logic             rf_we,
  input  logic [RF_IW-1:0] rf_idx,
  input  logic [7:0]       rf_wdata,
  input  logic             clr_notify,
  input  logic             clr_event,
  input  logic [7:0]       cmd_q,
  input  logic [7:0]       data_q,
  input  logic [7:0]       naddr_q,
  input  logic [7:0]       nlo_q,
  input  logic [7:0]       nhi_q,
  input  logic             wr_commit,
  input  logic             nt_commit,
  input  logic             rd_commit,
  output logic [6:0]       own_addr,
  output logic [7:0]       rd_byte,
  output logic [7:0]       rx_cmd,
  output logic [7:0]       rx_data,
  output logic [7:0]       nt_addr,
  output logic [15:0]      nt_data,
  output logic             stat_notify,
  output logic             stat_event
);
  logic [7:0] rf [RF_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           own_addr <= ADDR_AT_RESET;
    else if (cfg_addr_we) own_addr <= cfg_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_DEPTH; i++) rf[i] <= '0;
    end else if (rf_we && 32'(rf_idx) < RF_DEPTH) begin
      rf[rf_idx] <= rf_wdata;
    end
  end

  always_comb begin
    if (32'(cmd_q) < RF_DEPTH) rd_byte = rf[cmd_q[RF_IW-1:0]];
    else                       rd_byte = FILL_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cmd <= '0; rx_data <= '0; nt_addr <= '0; nt_data <= '0;
    end else begin
      if (wr_commit) begin
        rx_cmd  <= cmd_q;
        rx_data <= data_q;
      end
      if (nt_commit) begin
        nt_addr <= naddr_q;
        nt_data <= notify_word(nlo_q, nhi_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_notify <= 1'b0;
      stat_event  <= 1'b0;
    end else begin
      if (nt_commit)       stat_notify <= 1'b1;
      else if (clr_notify) stat_notify <= 1'b0;
      if (wr_commit || rd_commit) stat_event <= 1'b1;
      else if (clr_event)         stat_event <= 1'b0;
    end
  end

  // R5: at most one message completes per cycle
  p_one_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_commit, nt_commit, rd_commit}));

  // R3: a completed write or read raises the event status
  p_evt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || rd_commit) |=> stat_event);

  // R5: notify raises its own status and leaves the event status alone
  p_notify_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_commit && !clr_event) |=> stat_notify && $stable(stat_event));

  // R1: own address moves only on a host write
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_addr_we) |-> $stable(own_addr));

endmodule

// File: rtl/smb_slave_decoder.sv
module smb_slave_decoder #(
  parameter int RF_DEPTH    = 8,
  parameter int TO_CYC      = 5000,
  parameter int SYNC_STAGES = 2,
  localparam int RF_IW = (RF_DEPTH > 1) ? $clog2(RF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             cfg_addr_we,
  input  logic [6:0]       cfg_addr,
  input  logic             rf_we,
  input  logic [RF_IW-1:0] rf_idx,
  input  logic [7:0]       rf_wdata,
  input  logic             clr_notify,
  input  logic             clr_event,
  output logic [6:0]       slv_addr,
  output logic [7:0]       rx_cmd,
  output logic [7:0]       rx_data,
  output logic [7:0]       nt_addr,
  output logic [15:0]      nt_data,
  output logic             stat_notify,
  output logic             stat_event,
  output logic             irq_notify,
  output logic             irq_event
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] rd_byte, cmd_q, data_q, naddr_q, nlo_q, nhi_q;
  logic wr_commit, nt_commit, rd_commit;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_msg_fsm #(.TO_CYC(TO_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(slv_addr), .rd_byte(rd_byte), .sda_oe(sda_oe_o),
    .cmd_q(cmd_q), .data_q(data_q), .naddr_q(naddr_q), .nlo_q(nlo_q), .nhi_q(nhi_q),
    .wr_commit(wr_commit), .nt_commit(nt_commit), .rd_commit(rd_commit)
  );

  smb_regs #(.RF_DEPTH(RF_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .clr_notify(clr_notify), .clr_event(clr_event),
    .cmd_q(cmd_q), .data_q(data_q), .naddr_q(naddr_q), .nlo_q(nlo_q), .nhi_q(nhi_q),
    .wr_commit(wr_commit), .nt_commit(nt_commit), .rd_commit(rd_commit),
    .own_addr(slv_addr), .rd_byte(rd_byte),
    .rx_cmd(rx_cmd), .rx_data(rx_data), .nt_addr(nt_addr), .nt_data(nt_data),
    .stat_notify(stat_notify), .stat_event(stat_event)
  );

  assign irq_notify = stat_notify;
  assign irq_event  = stat_event;

endmodule

// File: tb/sim_smb_slave_decoder.sv
module sim_smb_slave_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int TO = 200;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_oe;
  logic cfg_we = 1'b0; logic [6:0] cfg_a = '0;
  logic rf_we = 1'b0; logic [2:0] rf_idx = '0; logic [7:0] rf_wd = '0;
  logic clr_n = 1'b0, clr_e = 1'b0;
  logic [6:0] slv_addr; logic [7:0] rx_cmd, rx_data, nt_addr; logic [15:0] nt_data;
  logic st_n, st_e, irq_n, irq_e;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smb_slave_decoder #(.RF_DEPTH(DEPTH), .TO_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .cfg_addr_we(cfg_we), .cfg_addr(cfg_a), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wd),
    .clr_notify(clr_n), .clr_event(clr_e), .slv_addr(slv_addr), .rx_cmd(rx_cmd),
    .rx_data(rx_data), .nt_addr(nt_addr), .nt_data(nt_data), .stat_notify(st_n),
    .stat_event(st_e), .irq_notify(irq_n), .irq_event(irq_e)
  );

  typedef struct packed { logic [6:0] a; logic [7:0] c; logic [7:0] d; logic hit; } wv_t;
  localparam int NV = 6;
  localparam wv_t WV [NV] = '{
    '{7'h44, 8'h01, 8'h5A, 1'b1}, '{7'h45, 8'h02, 8'h11, 1'b0},
    '{7'h44, 8'h07, 8'hC3, 1'b1}, '{7'h22, 8'h03, 8'h99, 1'b0},
    '{7'h44, 8'hFF, 8'h00, 1'b1}, '{7'h04, 8'h10, 8'h77, 1'b0}
  };

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start; sda_m = 1; scl = 1; w(2*Q); sda_m = 0; w(2*Q); scl = 0; w(Q); endtask
  task automatic bus_stop;  sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(2*Q); endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1; w(2*Q); scl = 0; w(Q);
    end
    sda_m = 1; w(Q); scl = 1; w(Q); ack = ~sda_bus; w(Q); scl = 0; w(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; w(Q); scl = 1; w(Q); b[i] = sda_bus; w(Q); scl = 0; w(Q);
    end
    sda_m = ~mack; w(Q); scl = 1; w(2*Q); scl = 0; w(Q); sda_m = 1;
  endtask

  task automatic byte_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                            output logic ack);
    logic k;
    bus_start; send_byte({a, 1'b0}, ack);
    if (ack) begin send_byte(c, k); send_byte(d, k); end
    bus_stop;
  endtask

  task automatic clear_evt; clr_e = 1; w(1); clr_e = 0; w(1); endtask

  initial begin
    logic ack, a2, a3, a4;
    logic [7:0] rb, exp_c, exp_d;
    w(3); rst_n = 1; w(3);

    // R1 reset state
    chk("R1 reset addr", 32'(slv_addr), 32'h44);
    chk("R8 reset status", {st_n, st_e, irq_n, irq_e}, 0);
    chk("R3 reset rx_data", 32'(rx_data), 0);
    chk("R10 idle no drive", 32'(sda_oe), 0);

    // R2/R3 table of byte writes
    exp_c = 8'h00; exp_d = 8'h00;
    for (int k = 0; k < NV; k++) begin
      byte_write(WV[k].a, WV[k].c, WV[k].d, ack);
      chk("R2 address ack", 32'(ack), 32'(WV[k].hit));
      if (WV[k].hit) begin exp_c = WV[k].c; exp_d = WV[k].d; end
      chk("R3 rx_cmd", 32'(rx_cmd), 32'(exp_c));
      chk("R3 rx_data", 32'(rx_data), 32'(exp_d));
      chk("R3 event status", 32'(st_e), 32'(WV[k].hit));
      chk("R8 irq follows status", 32'(irq_e), 32'(WV[k].hit));
      clear_evt;
      chk("R8 clear event", 32'(st_e), 0);
    end

    // R4 byte read, in range and out of range
    rf_we = 1; rf_idx = 3'd3; rf_wd = 8'hA5; w(1); rf_idx = 3'd5; rf_wd = 8'h3C; w(1); rf_we = 0; w(1);
    bus_start; send_byte(8'h88, a2); send_byte(8'h03, a3);
    bus_start; send_byte(8'h89, a4); read_byte(rb, 1'b0); bus_stop;
    chk("R4 acks", {a2, a3, a4}, 3'b111);
    chk("R4 read data idx3", 32'(rb), 32'hA5);
    chk("R4 read event status", 32'(st_e), 1);
    clear_evt;
    bus_start; send_byte(8'h88, a2); send_byte(8'h05, a3);
    bus_start; send_byte(8'h89, a4); read_byte(rb, 1'b0); bus_stop;
    chk("R4 read data idx5", 32'(rb), 32'h3C);
    bus_start; send_byte(8'h88, a2); send_byte(8'd9, a3);
    bus_start; send_byte(8'h89, a4); read_byte(rb, 1'b0); bus_stop;
    chk("R4 out of range fill", 32'(rb), 32'hFF);
    clear_evt;

    // R9 read without command
    bus_start; send_byte(8'h89, ack); bus_stop;
    chk("R9 read without command nack", 32'(ack), 0);
    chk("R9 no event", 32'(st_e), 0);

    // R5 host notify
    bus_start; send_byte(8'h10, a2); send_byte(8'h2A, a3); send_byte(8'h34, a4); send_byte(8'h12, ack); bus_stop;
    chk("R5 notify acks", {a2, a3, a4, ack}, 4'hF);
    chk("R5 notify device", 32'(nt_addr), 32'h2A);
    chk("R5 notify word", 32'(nt_data), (32'h12 << 8) | 32'h34);
    chk("R5 notify status", {st_n, irq_n}, 2'b11);
    chk("R5 event untouched", 32'(st_e), 0);
    clr_n = 1; w(1); clr_n = 0; w(1);
    chk("R8 clear notify", 32'(st_n), 0);

    // R6 extra byte after a full write
    bus_start; send_byte(8'h88, a2); send_byte(8'h20, a3); send_byte(8'h66, a4); send_byte(8'h99, ack); bus_stop;
    chk("R6 extra byte nack", 32'(ack), 0);
    chk("R6 discarded", 32'(rx_data), 32'(exp_d));
    chk("R6 no event", 32'(st_e), 0);

    // R7 bus idle timeout mid-transfer
    bus_start; send_byte(8'h88, a2); send_byte(8'h30, a3); send_byte(8'h77, a4);
    scl = 1; sda_m = 1; w(TO + 60);
    scl = 0; w(Q); sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(2*Q);
    chk("R7 timeout no commit", 32'(rx_data), 32'(exp_d));
    chk("R7 timeout no event", 32'(st_e), 0);
    byte_write(7'h44, 8'h31, 8'h42, ack);
    chk("R7 recovery write", {ack, rx_data}, {1'b1, 8'h42});
    clear_evt;

    // R1 reprogram own address
    cfg_a = 7'h31; cfg_we = 1; w(1); cfg_we = 0; w(1);
    chk("R1 programmed addr", 32'(slv_addr), 32'h31);
    byte_write(7'h31, 8'h0A, 8'hE7, ack);
    chk("R1 new address acked", {ack, rx_data}, {1'b1, 8'hE7});
    byte_write(7'h44, 8'h0B, 8'h18, ack);
    chk("R2 old address nack", {ack, rx_data}, {1'b0, 8'hE7});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule